// File: doc/BRIEF.md
# TFT Panel Output Timing Stage

This block is the last stage before a TFT flat panel. It receives a line sync, a display-enable and pixel data from an upstream timing source, all timed by the dot clock. From these it drives the panel pins: a horizontal sync whose width it sets itself, a data strobe whose polarity can be chosen, a shift clock that is either gated or free-running, and registered pixel data. A single 64-bit control word holds the settings. Software writes and reads it over a plain register port.

Writes land in a pending copy of the control word, which reads back at once. The settings that steer the pins are copied from the pending word only on the next rising edge of the incoming line sync, so a line that is already running keeps its settings to the end. A bypass setting sends the raw input timing and pixels straight to the pins.

Top module: `tft_panel_out`

## Requirements
- R1: While reset is held, and after it, the control word reads zero. The panel sync output, the strobe output and the pixel output are all zero, and the shift clock stays low.
- R2: The control word keeps only bits 31, 30, 29, 27 and 4:0 of a write. Every other bit, bits 63:32 included, reads back as 0. A write of all ones reads back as 0x00000000E800001F.
- R3: Let N (1 to 31) be the value of control bits 4:0. A rising edge of the input sync, seen at clock edge k, drives the panel sync output high from edge k to edge k+N, so the pulse lasts exactly N dot clocks.
- R4: If bits 4:0 are 0 when the input sync rises, no sync pulse is produced and any pulse already running ends.
- R5: A new input sync rising edge that arrives while a pulse is still running reloads the count to N from that edge.
- R6: A write shows on the read port from the next clock. It changes pin behaviour only from the next rising edge of the input sync.
- R7: In normal mode (bit 30 = 0), the pixel output and the strobe output equal the inputs as they stood at the previous dot clock edge.
- R8: Bit 29 = 1 inverts the strobe output, so the strobe is active low. Bit 29 = 0 leaves it active high.
- R9: Bit 27 = 0 gates the shift clock. Each high phase of the shift clock happens only when the delayed display-enable was high. Bit 27 = 1 lets the shift clock pulse in every dot clock period.
- R10: In bypass mode (bit 30 = 1), the sync, strobe and pixel outputs follow the inputs with no delay, and the shift clock pulses every period.
- R11: Bit 31 can be stored and read back but has no effect on any output.
- R12: The shift clock rises only while the dot clock is high and falls only while the dot clock is low, so it never produces a runt pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dotClk | input | 1 | Dot clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hsyncIn | input | 1 | Line sync from the timing source, active high |
| deIn | input | 1 | Display-enable from the timing source |
| pixIn | input | PIX_W | Pixel data from the timing source |
| regWe | input | 1 | Write strobe for the control word |
| regWdata | input | 64 | Write data for the control word |
| regRdata | output | 64 | Pending control word as read back |
| hsyncOut | output | 1 | Panel line sync |
| deOut | output | 1 | Panel data strobe, polarity set by bit 29 |
| pixOut | output | PIX_W | Panel pixel data |
| shiftClk | output | 1 | Panel shift clock |

## Verification
The hardest cases to reach from the ports involve the line sync edge. One is a second sync rise that arrives while a long pulse is still counting down. Another is a write that lands in the middle of a line, where the read port already shows the new value but the pins must not change until the next sync rise. The stimulus sets a pulse width of 20 and then sends two short sync pulses three cycles apart. It also issues a write while the sync input is still high, and the stimulus leaves bypass mode while the data-enable is low, so the clock gate has to close cleanly. A behavioural model, updated on every edge, predicts each pin in each of these windows.

// File: rtl/tft_panel_pkg.sv
`timescale 1ns/100ps
package tft_panel_pkg;
  localparam int REG_W     = 64;
  localparam int WID_BITS  = 5;
  localparam int SPARE_BIT = 31;
  localparam int PASS_BIT  = 30;
  localparam int POL_BIT   = 29;
  localparam int FREE_BIT  = 27;

  // Bits that hold state; everything else reads as zero.
  localparam logic [REG_W-1:0] WR_MASK =
      (REG_W'(1) << SPARE_BIT) | (REG_W'(1) << PASS_BIT) |
      (REG_W'(1) << POL_BIT)   | (REG_W'(1) << FREE_BIT) |
      ((REG_W'(1) << WID_BITS) - REG_W'(1));

  // Strobes passed from the control side to the datapath.
  typedef struct packed {
    logic passThru;
    logic strobeLow;
    logic freeRun;
    logic hsPulse;
  } tftStrobe_t;
endpackage

// File: rtl/tft_hs_stretch.sv
`timescale 1ns/100ps
module tft_hs_stretch #(
  parameter int CNT_W = 5
) (
  input  logic             dotClk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] width,
  output logic             pulse,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge dotClk or negedge rstN) begin
    if (!rstN)             cntQ <= '0;
    else if (start)        cntQ <= width;
    else if (cntQ != '0)   cntQ <= cntQ - 1'b1;
  end

  assign pulse = (cntQ != '0);
  assign count = cntQ;
endmodule

// File: rtl/tft_panel_ctrl.sv
`timescale 1ns/100ps
module tft_panel_ctrl
  import tft_panel_pkg::*;
(
  input  logic                dotClk,
  input  logic                rstN,
  input  logic                hsyncIn,
  input  logic                regWe,
  input  logic [REG_W-1:0]    regWdata,
  output logic [REG_W-1:0]    regRdata,
  output tftStrobe_t          strobe,
  output logic                lineStart,
  output logic [WID_BITS-1:0] pulseCnt
);
  logic [REG_W-1:0] pendReg;
  logic             hsPrev;
  logic             actPass, actPol, actFree;
  logic             hsPulse;

  assign lineStart = hsyncIn & ~hsPrev;

  always_ff @(posedge dotClk or negedge rstN) begin
    if (!rstN) begin
      pendReg <= '0;
      hsPrev  <= 1'b0;
      actPass <= 1'b0;
      actPol  <= 1'b0;
      actFree <= 1'b0;
    end else begin
      hsPrev <= hsyncIn;
      if (regWe) pendReg <= regWdata & WR_MASK;
      if (lineStart) begin
        actPass <= pendReg[PASS_BIT];
        actPol  <= pendReg[POL_BIT];
        actFree <= pendReg[FREE_BIT];
      end
    end
  end

  tft_hs_stretch #(.CNT_W(WID_BITS)) u_stretch (
    .dotClk (dotClk),
    .rstN   (rstN),
    .start  (lineStart),
    .width  (pendReg[WID_BITS-1:0]),
    .pulse  (hsPulse),
    .count  (pulseCnt)
  );

  assign regRdata = pendReg;

  always_comb begin
    strobe.passThru  = actPass;
    strobe.strobeLow = actPol;
    strobe.freeRun   = actFree;
    strobe.hsPulse   = hsPulse;
  end
endmodule

// File: rtl/tft_panel_dp.sv
`timescale 1ns/100ps
module tft_panel_dp
  import tft_panel_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             dotClk,
  input  logic             rstN,
  input  tftStrobe_t       strobe,
  input  logic             hsyncIn,
  input  logic             deIn,
  input  logic [PIX_W-1:0] pixIn,
  output logic             hsyncOut,
  output logic             deOut,
  output logic [PIX_W-1:0] pixOut,
  output logic             shiftClk
);
  logic             deD;
  logic [PIX_W-1:0] pixD;
  logic             gateQ;

  always_ff @(posedge dotClk or negedge rstN) begin
    if (!rstN) begin
      deD  <= 1'b0;
      pixD <= '0;
    end else begin
      deD  <= deIn;
      pixD <= pixIn;
    end
  end

  // Gate is captured on the falling edge, so it only moves in the low phase.
  always_ff @(negedge dotClk or negedge rstN) begin
    if (!rstN) gateQ <= 1'b0;
    else       gateQ <= strobe.passThru | strobe.freeRun | deD;
  end

  assign shiftClk = dotClk & gateQ;

  always_comb begin
    if (strobe.passThru) begin
      hsyncOut = hsyncIn;
      deOut    = deIn;
      pixOut   = pixIn;
    end else begin
      hsyncOut = strobe.hsPulse;
      deOut    = deD ^ strobe.strobeLow;
      pixOut   = pixD;
    end
  end
endmodule

// File: rtl/tft_panel_out.sv
`timescale 1ns/100ps
module tft_panel_out
  import tft_panel_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             dotClk,
  input  logic             rstN,
  input  logic             hsyncIn,
  input  logic             deIn,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             regWe,
  input  logic [63:0]      regWdata,
  output logic [63:0]      regRdata,
  output logic             hsyncOut,
  output logic             deOut,
  output logic [PIX_W-1:0] pixOut,
  output logic             shiftClk
);
  tftStrobe_t          strobe;
  logic                lineStart;
  logic [WID_BITS-1:0] pulseCnt;

  tft_panel_ctrl u_ctrl (
    .dotClk    (dotClk),
    .rstN      (rstN),
    .hsyncIn   (hsyncIn),
    .regWe     (regWe),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .strobe    (strobe),
    .lineStart (lineStart),
    .pulseCnt  (pulseCnt)
  );

  tft_panel_dp #(.PIX_W(PIX_W)) u_dp (
    .dotClk   (dotClk),
    .rstN     (rstN),
    .strobe   (strobe),
    .hsyncIn  (hsyncIn),
    .deIn     (deIn),
    .pixIn    (pixIn),
    .hsyncOut (hsyncOut),
    .deOut    (deOut),
    .pixOut   (pixOut),
    .shiftClk (shiftClk)
  );
endmodule

// File: rtl/tft_panel_chk.sv
`timescale 1ns/100ps
module tft_panel_chk
  import tft_panel_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input logic                dotClk,
  input logic                rstN,
  input logic                hsyncIn,
  input logic                deIn,
  input logic [PIX_W-1:0]    pixIn,
  input logic [63:0]         regRdata,
  input logic                hsyncOut,
  input logic                deOut,
  input logic [PIX_W-1:0]    pixOut,
  input logic                shiftClk,
  input tftStrobe_t          strobe,
  input logic                lineStart,
  input logic [WID_BITS-1:0] pulseCnt
);
  a_r3_countdown: assert property (@(posedge dotClk) disable iff (!rstN)
    (!lineStart && pulseCnt != '0) |=> pulseCnt == $past(pulseCnt) - 1'b1);

  a_r5_reload: assert property (@(posedge dotClk) disable iff (!rstN)
    lineStart |=> pulseCnt == $past(regRdata[WID_BITS-1:0]));

  a_r4_zero_width: assert property (@(posedge dotClk) disable iff (!rstN)
    (lineStart && regRdata[WID_BITS-1:0] == '0 && !regRdata[PASS_BIT]) |=> !hsyncOut);

  a_r6_hold_mid_line: assert property (@(posedge dotClk) disable iff (!rstN)
    !lineStart |=> ($stable(strobe.passThru) && $stable(strobe.strobeLow) && $stable(strobe.freeRun)));

  a_r10_bypass: assert property (@(posedge dotClk) disable iff (!rstN)
    strobe.passThru |-> (hsyncOut == hsyncIn && deOut == deIn && pixOut == pixIn));

  always @(posedge shiftClk) if (rstN) a_r12_rise_in_high: assert (dotClk);
  always @(negedge shiftClk) if (rstN) a_r12_fall_in_low: assert (!dotClk);
endmodule

bind tft_panel_out tft_panel_chk #(.PIX_W(PIX_W)) u_chk (
  .dotClk    (dotClk),
  .rstN      (rstN),
  .hsyncIn   (hsyncIn),
  .deIn      (deIn),
  .pixIn     (pixIn),
  .regRdata  (regRdata),
  .hsyncOut  (hsyncOut),
  .deOut     (deOut),
  .pixOut    (pixOut),
  .shiftClk  (shiftClk),
  .strobe    (strobe),
  .lineStart (lineStart),
  .pulseCnt  (pulseCnt)
);

// File: tb/test_tft_panel_out.sv
`timescale 1ns/100ps
module test_tft_panel_out;
  localparam int PIX_W = 24;
  localparam logic [63:0] KEEP = 64'h0000_0000_E800_001F;

  logic             dotClk = 1'b0;
  logic             rstN = 1'b0;
  logic             hsyncIn = 1'b0;
  logic             deIn = 1'b0;
  logic [PIX_W-1:0] pixIn = '0;
  logic             regWe = 1'b0;
  logic [63:0]      regWdata = '0;
  logic [63:0]      regRdata;
  logic             hsyncOut, deOut, shiftClk;
  logic [PIX_W-1:0] pixOut;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";

  tft_panel_out #(.PIX_W(PIX_W)) i_tft_panel_out (
    .dotClk(dotClk), .rstN(rstN), .hsyncIn(hsyncIn), .deIn(deIn), .pixIn(pixIn),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .hsyncOut(hsyncOut), .deOut(deOut), .pixOut(pixOut), .shiftClk(shiftClk)
  );

  always #2.5 dotClk = ~dotClk;   // 200 MHz

  // Behavioural reference state
  logic [63:0]      mPend = '0;
  int               mCnt = 0;
  bit               mHsPrev, mDeD, mPass, mPol, mFree, mGate, mRise;
  logic [PIX_W-1:0] mPix = '0;

  always @(posedge dotClk) begin
    if (!rstN) begin
      mPend = '0; mCnt = 0; mHsPrev = 0; mDeD = 0; mPass = 0; mPol = 0; mFree = 0; mPix = '0;
    end else begin
      mRise   = hsyncIn && !mHsPrev;
      mHsPrev = hsyncIn;
      if (mRise) begin
        mPass = mPend[30]; mPol = mPend[29]; mFree = mPend[27];
        mCnt  = int'(mPend[4:0]);
      end else if (mCnt > 0) begin
        mCnt = mCnt - 1;
      end
      if (regWe) mPend = regWdata & KEEP;
      mDeD = deIn;
      mPix = pixIn;
    end
  end

  always @(negedge dotClk) mGate = rstN ? (mPass | mFree | mDeD) : 1'b0;

  task automatic chk(string req, string sig, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, sig, act, exp);
    end
  endtask

  // Compare on every clock: shift clock in the high phase, the rest in the low phase.
  always @(posedge dotClk) begin
    #1;
    chk((curReq == "R1") ? "R1" : "R9/R12", "shiftClk", 64'(shiftClk), 64'(mGate));
    #3;
    chk(curReq, "regRdata", regRdata, mPend);
    if (mPass) begin
      chk(curReq, "hsyncOut", 64'(hsyncOut), 64'(hsyncIn));
      chk(curReq, "deOut", 64'(deOut), 64'(deIn));
      chk(curReq, "pixOut", 64'(pixOut), 64'(pixIn));
    end else begin
      chk(curReq, "hsyncOut", 64'(hsyncOut), 64'(mCnt != 0));
      chk(curReq, "deOut", 64'(deOut), 64'(mDeD ^ mPol));
      chk(curReq, "pixOut", 64'(pixOut), 64'(mPix));
    end
  end

  task automatic tick();
    @(posedge dotClk);
    #2;
  endtask

  task automatic wr(logic [63:0] v);
    regWe = 1'b1; regWdata = v;
    tick();
    regWe = 1'b0;
  endtask

  task automatic line(int hsLen, int gap, int deLen);
    hsyncIn = 1'b1;
    repeat (hsLen) tick();
    hsyncIn = 1'b0;
    repeat (gap) tick();
    deIn = 1'b1;
    for (int i = 0; i < deLen; i++) begin
      pixIn = pixIn + 24'h010203;
      tick();
    end
    deIn = 1'b0;
    repeat (4) tick();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge dotClk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    curReq = "R1";
    repeat (3) tick();
    chk("R1", "regRdata", regRdata, 64'h0);
    chk("R1", "hsyncOut", 64'(hsyncOut), 64'h0);
    rstN = 1'b1;
    repeat (2) tick();

    curReq = "R2";
    wr('1);
    #2 chk("R2", "regRdata all ones", regRdata, 64'h0000_0000_E800_001F);
    wr(64'h0);

    curReq = "R3";
    wr(64'd5);
    line(2, 8, 6);
    line(3, 6, 10);
    wr(64'd1);
    line(1, 4, 5);
    wr(64'd31);
    line(2, 35, 4);

    curReq = "R6";
    wr(64'd7);
    line(2, 10, 3);
    hsyncIn = 1'b1; tick(); tick();
    wr(64'd2);
    #2 chk("R6", "regRdata after write", regRdata, 64'd2);
    hsyncIn = 1'b0;
    repeat (12) tick();
    line(2, 5, 3);

    curReq = "R5";
    wr(64'd20);
    hsyncIn = 1'b1; tick(); tick();
    hsyncIn = 1'b0; repeat (3) tick();
    hsyncIn = 1'b1; tick(); tick();
    hsyncIn = 1'b0; repeat (30) tick();

    curReq = "R4";
    wr(64'd0);
    line(3, 5, 6);
    line(4, 5, 6);

    curReq = "R8";
    wr((64'd1 << 29) | 64'd4);
    line(2, 5, 8);
    line(2, 5, 8);

    curReq = "R9";
    wr((64'd1 << 27) | 64'd4);
    line(2, 5, 8);
    line(2, 5, 8);

    curReq = "R11";
    wr((64'd1 << 31) | 64'd6);
    line(2, 5, 8);
    line(2, 5, 8);

    curReq = "R10";
    wr(64'd1 << 30);
    line(2, 5, 8);
    line(3, 4, 6);
    wr(64'd3);
    line(2, 5, 6);

    curReq = "R7";
    wr(64'd4);
    line(2, 3, 12);
    line(1, 2, 20);
    repeat (5) tick();

    summary();
  end
endmodule